// File: doc/BRIEF.md
# Queued SPI Master Command Engine

This block is an SPI master that runs a queue of command words. Software pushes 32-bit commands into a four-deep transmit queue. Each command holds up to 16 bits of transmit data and the controls for its own frame: which chip-select line to drive, whether that line stays asserted after the frame, which stored attribute set (frame length, clock polarity, clock phase, bit order) to use, whether the counter is cleared first, and whether the frame ends the queue. The engine takes one command at a time and shifts the frame out. It places each received frame into a four-deep receive queue, which software reads one word at a time.

When a frame marked end-of-queue has finished, the engine sets a status flag and stops taking commands. It raises an interrupt if that is enabled, and it resumes once the flag is cleared by writing a one to it. The serial clock is paced by a `tick` input from a separate divider. Each tick is one half-period of SCK. A small word-addressed register port gives access to control, status, interrupt enable, push, pop, the frame counter and the attribute sets.

Register word addresses: 0 control (bit 0 flushes the transmit queue and bit 1 flushes the receive queue, both on write; bits 21:16 hold the per-line idle levels of the chip selects), 1 status, 2 interrupt enable, 3 push, 4 pop, 5 counter, 8 + k attribute set k.

Top module: `spi_cmdq`

## Requirements
- R1: The transmit queue holds four commands and sends them in push order. A push to a full queue is dropped and sets the sticky overflow bit, status bit 0. Writing 1 to status bit 0 clears it.
- R2: A pop from an empty receive queue returns 0 and sets the sticky underflow bit, status bit 1. Writing 1 to status bit 1 clears it.
- R3: Command bits 21:16 are a one-hot chip-select field for lines 0..5. Bits 30:28 pick the attribute set, and only the low log2(NATTR) bits are used. Bits 15:0 are the transmit data.
- R4: An attribute set keeps frame length minus one in bits 30:27, so frames of 4 to 16 bits are legal. Bit 24 set sends and receives LSB first. Bit 24 clear sends MSB first.
- R5: Attribute bit 26 (CPOL) sets the SCK idle level, which is 0 after reset. Attribute bit 25 (CPHA) selects the sampling edge: clear samples on the leading edge and set samples on the trailing edge.
- R6: A received frame appears right-aligned in pop bits 15:0 and all higher bits read as zero. The first bit on the wire lands at the data MSB when MSB-first and at bit 0 when LSB-first.
- R7: When a frame with command bit 27 set has finished, status bit 28 is set and no further command is taken until a 1 is written to status bit 28.
- R8: The `irq` output is high exactly when status bit 28 and interrupt-enable bit 28 are both set.
- R9: With command bit 31 set, the chip select stays asserted after the frame. With bit 31 clear, it is released for at least two ticks (one SCK period) before the next frame begins.
- R10: The 16-bit counter at address 5 increments once per finished frame. Command bit 26 clears it before that command's frame is sent. The counter is 0 after reset.
- R11: A control write with bit 0 set empties the transmit queue, and one with bit 1 set empties the receive queue.
- R12: Control bits 21:16 give each chip-select line its idle level. A 1 means idle high (active low), and the reset value is all ones.
- R13: SCK changes only on cycles where `tick` is high, one edge per tick during a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Half-period pulse from the SCK divider |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops on address 4) |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq | output | 1 | End-of-queue interrupt |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 6 | Chip-select lines |

## Verification
The assertions assume that every pushed command carries a chip-select field with at most one bit set. They also assume that frame lengths are 4 to 16 bits and that the receive queue is never full when a frame ends. The bench keeps to these limits: each command it builds selects a single line, it pops or flushes the receive queue before pushing more frames than it can hold, and the sweep covers only lengths 4 through 16. MISO is wired to the inverse of MOSI, so every received word has a known value even when data and bit order vary.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_SHIFT = 3'd2,
    ST_END   = 3'd3,
    ST_GAP   = 3'd4
  } eng_state_t;

  typedef struct packed {
    logic [3:0] fmsz;
    logic       cpol;
    logic       cpha;
    logic       lsb;
  } frame_attr_t;

  localparam int CMD_KEEP = 31;
  localparam int CMD_SEL  = 28;
  localparam int CMD_EOQ  = 27;
  localparam int CMD_CLR  = 26;
  localparam int CMD_CS   = 16;
  localparam int STAT_EOQ = 28;

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_STAT = 4'h1;
  localparam logic [3:0] A_IEN  = 4'h2;
  localparam logic [3:0] A_PUSH = 4'h3;
  localparam logic [3:0] A_POP  = 4'h4;
  localparam logic [3:0] A_CNT  = 4'h5;

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_q];
  assign count   = cnt_q;

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = wr_q + 1'b1;
      if (do_pop)  rd_d = rd_q + 1'b1;
      if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_q] <= din;
  end

endmodule

// File: rtl/cmdq_shifter.sv
module cmdq_shifter
  import cmdq_pkg::*;
#(
  parameter int NCS = 6,
  parameter int DW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            cmd_valid,
  input  logic [31:0]     cmd,
  input  frame_attr_t     attr,
  input  logic            miso,
  output logic            cmd_pop,
  output logic            clr_cnt,
  output logic            done,
  output logic            done_eoq,
  output logic            keep,
  output logic [DW-1:0]   rx_word,
  output logic            sck,
  output logic            mosi,
  output logic [NCS-1:0]  cs_act
);
  localparam int IW = $clog2(DW);
  localparam int EW = IW + 1;

  eng_state_t    st_q, st_d;
  logic [DW-1:0] dat_q, dat_d, rx_q, rx_d;
  logic [NCS-1:0] csel_q, csel_d;
  logic          cont_q, cont_d, eoq_q, eoq_d, sck_q, sck_d, gap_q, gap_d;
  frame_attr_t   attr_q, attr_d;
  logic [EW-1:0] ecnt_q, ecnt_d, out_e;
  logic [IW-1:0] jo, ji, tx_pos, rx_pos;
  logic          last_edge;

  wire unused_cmd = ^{cmd[30:28], cmd[25:CMD_CS+NCS]};

  assign out_e     = (attr_q.cpha && ecnt_q != '0) ? ecnt_q - 1'b1 : ecnt_q;
  assign jo        = out_e[EW-1:1];
  assign ji        = ecnt_q[EW-1:1];
  assign tx_pos    = attr_q.lsb ? jo : (IW'(attr_q.fmsz) - jo);
  assign rx_pos    = attr_q.lsb ? ji : (IW'(attr_q.fmsz) - ji);
  assign last_edge = (ecnt_q == EW'({attr_q.fmsz, 1'b1}));

  assign cmd_pop  = (st_q == ST_IDLE) && cmd_valid;
  assign clr_cnt  = cmd_pop && cmd[CMD_CLR];
  assign done     = (st_q == ST_END);
  assign done_eoq = done && eoq_q;
  assign keep     = cont_q;
  assign rx_word  = rx_q;
  assign sck      = sck_q;
  assign mosi     = dat_q[tx_pos];
  assign cs_act   = csel_q;

  always_comb begin
    st_d   = st_q;
    dat_d  = dat_q;
    rx_d   = rx_q;
    csel_d = csel_q;
    cont_d = cont_q;
    eoq_d  = eoq_q;
    sck_d  = sck_q;
    gap_d  = gap_q;
    attr_d = attr_q;
    ecnt_d = ecnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          dat_d  = cmd[DW-1:0];
          csel_d = cmd[CMD_CS +: NCS];
          cont_d = cmd[CMD_KEEP];
          eoq_d  = cmd[CMD_EOQ];
          attr_d = attr;
          sck_d  = attr.cpol;
          ecnt_d = '0;
          rx_d   = '0;
          st_d   = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tick) st_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (tick) begin
          sck_d = ~sck_q;
          if (ecnt_q[0] == attr_q.cpha) rx_d[rx_pos] = miso;
          if (last_edge) st_d = ST_END;
          else           ecnt_d = ecnt_q + 1'b1;
        end
      end
      ST_END: begin
        if (cont_q) begin
          st_d = ST_IDLE;
        end else begin
          csel_d = '0;
          gap_d  = 1'b0;
          st_d   = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tick) begin
          gap_d = 1'b1;
          if (gap_q) st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dat_q  <= '0;
      rx_q   <= '0;
      csel_q <= '0;
      cont_q <= 1'b0;
      eoq_q  <= 1'b0;
      sck_q  <= 1'b0;
      gap_q  <= 1'b0;
      attr_q <= '0;
      ecnt_q <= '0;
    end else begin
      st_q   <= st_d;
      dat_q  <= dat_d;
      rx_q   <= rx_d;
      csel_q <= csel_d;
      cont_q <= cont_d;
      eoq_q  <= eoq_d;
      sck_q  <= sck_d;
      gap_q  <= gap_d;
      attr_q <= attr_d;
      ecnt_q <= ecnt_d;
    end
  end

endmodule

// File: rtl/spi_cmdq.sv
module spi_cmdq
  import cmdq_pkg::*;
#(
  parameter int NCS   = 6,
  parameter int DW    = 16,
  parameter int TXD   = 4,
  parameter int RXD   = 4,
  parameter int NATTR = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [3:0]     addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic           irq,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  localparam int SELW = (NATTR > 1) ? $clog2(NATTR) : 1;
  localparam int TCW  = $clog2(TXD) + 1;
  localparam int RCW  = $clog2(RXD) + 1;

  // reset: asserted asynchronously, released through two flops
  logic rs_q1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs_q1      <= 1'b1;
      rst_sync_n <= rs_q1;
    end
  end

  // register decode
  logic wr_ctrl, wr_stat, wr_ien, wr_push, rd_pop;
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_ien  = wr_en && (addr == A_IEN);
  assign wr_push = wr_en && (addr == A_PUSH);
  assign rd_pop  = rd_en && (addr == A_POP);

  // queues
  logic [31:0]    tx_head;
  logic           tx_full, tx_empty, rx_full, rx_empty;
  logic [TCW-1:0] tx_count;
  logic [RCW-1:0] unused_rx_count;
  logic [DW-1:0]  rx_head, rx_word;
  logic           cmd_pop, clr_cnt, done, done_eoq, eng_keep;
  logic [NCS-1:0] cs_act;

  cmdq_fifo #(.W(32), .DEPTH(TXD)) u_txq (
    .clk(clk), .rst_n(rst_sync_n), .flush(wr_ctrl && wdata[0]),
    .push(wr_push), .din(wdata), .pop(cmd_pop), .dout(tx_head),
    .full(tx_full), .empty(tx_empty), .count(tx_count)
  );

  cmdq_fifo #(.W(DW), .DEPTH(RXD)) u_rxq (
    .clk(clk), .rst_n(rst_sync_n), .flush(wr_ctrl && wdata[1]),
    .push(done), .din(rx_word), .pop(rd_pop), .dout(rx_head),
    .full(rx_full), .empty(rx_empty), .count(unused_rx_count)
  );
  wire unused_rx_full = rx_full;

  // attribute sets
  frame_attr_t attr_q [NATTR];
  for (genvar g = 0; g < NATTR; g++) begin : g_attr
    logic        wr_this;
    frame_attr_t a_d;
    assign wr_this = wr_en && (addr == 4'(8 + g));
    always_comb begin
      a_d = attr_q[g];
      if (wr_this) a_d = '{fmsz: wdata[30:27], cpol: wdata[26], cpha: wdata[25], lsb: wdata[24]};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) attr_q[g] <= '{fmsz: 4'd7, cpol: 1'b0, cpha: 1'b0, lsb: 1'b0};
      else        attr_q[g] <= a_d;
    end
  end

  logic [SELW-1:0] attr_sel;
  assign attr_sel = tx_head[CMD_SEL +: SELW];

  // status, enable, idle levels, counter
  logic           eoq_q, eoq_d, ovf_q, ovf_d, udf_q, udf_d, ien_q, ien_d;
  logic [NCS-1:0] pol_q, pol_d;
  logic [15:0]    cnt_q, cnt_d;

  always_comb begin
    eoq_d = done_eoq | (eoq_q & ~(wr_stat & wdata[STAT_EOQ]));
    ovf_d = (wr_push & tx_full) | (ovf_q & ~(wr_stat & wdata[0]));
    udf_d = (rd_pop & rx_empty) | (udf_q & ~(wr_stat & wdata[1]));
    ien_d = wr_ien ? wdata[STAT_EOQ] : ien_q;
    pol_d = wr_ctrl ? wdata[CMD_CS +: NCS] : pol_q;
    cnt_d = cnt_q;
    if (clr_cnt)   cnt_d = '0;
    else if (done) cnt_d = cnt_q + 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoq_q <= 1'b0;
      ovf_q <= 1'b0;
      udf_q <= 1'b0;
      ien_q <= 1'b0;
      pol_q <= '1;
      cnt_q <= '0;
    end else begin
      eoq_q <= eoq_d;
      ovf_q <= ovf_d;
      udf_q <= udf_d;
      ien_q <= ien_d;
      pol_q <= pol_d;
      cnt_q <= cnt_d;
    end
  end

  cmdq_shifter #(.NCS(NCS), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick),
    .cmd_valid(!tx_empty && !eoq_q), .cmd(tx_head), .attr(attr_q[attr_sel]),
    .miso(miso), .cmd_pop(cmd_pop), .clr_cnt(clr_cnt), .done(done),
    .done_eoq(done_eoq), .keep(eng_keep), .rx_word(rx_word),
    .sck(sck), .mosi(mosi), .cs_act(cs_act)
  );

  assign cs_n = pol_q ^ cs_act;
  assign irq  = eoq_q & ien_q;

  // read mux
  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: rdata[CMD_CS +: NCS] = pol_q;
      A_STAT: rdata = {3'b0, eoq_q, 26'b0, udf_q, ovf_q};
      A_IEN:  rdata[STAT_EOQ] = ien_q;
      A_POP:  rdata[DW-1:0] = rx_empty ? '0 : rx_head;
      A_CNT:  rdata[15:0] = cnt_q;
      default: begin
        if (addr[3] && (int'(addr[2:0]) < NATTR)) begin
          rdata[30:27] = attr_q[addr[SELW-1:0]].fmsz;
          rdata[26]    = attr_q[addr[SELW-1:0]].cpol;
          rdata[25]    = attr_q[addr[SELW-1:0]].cpha;
          rdata[24]    = attr_q[addr[SELW-1:0]].lsb;
        end
      end
    endcase
  end

endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker #(
  parameter int NCS = 6,
  parameter int TXD = 4,
  parameter int TCW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           sck,
  input logic           cmd_pop,
  input logic           done,
  input logic           keep,
  input logic [NCS-1:0] cs_act,
  input logic [TCW-1:0] tx_count,
  input logic [15:0]    cnt,
  input logic           eoq_flag
);

  // R1: the transmit queue never holds more than its depth
  p_txcap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= TXD);

  // R3: at most one chip-select line driven at a time
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_act));

  // R7: while halted on end-of-queue the counter does not move
  p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoq_flag |=> cnt == $past(cnt));

  // R9: a frame without keep releases its chip select right after it ends
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !keep |=> cs_act == '0);

  // R10: every finished frame advances the counter by one
  p_cnt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cnt == 16'($past(cnt) + 16'd1));

  // R13: SCK only moves on tick cycles (or when a frame loads its idle level)
  p_sck_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cmd_pop |=> $stable(sck));

endmodule

bind spi_cmdq cmdq_checker #(.NCS(NCS), .TXD(TXD), .TCW(TCW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick), .sck(sck),
  .cmd_pop(cmd_pop), .done(done), .keep(eng_keep), .cs_act(cs_act),
  .tx_count(tx_count), .cnt(cnt_q), .eoq_flag(eoq_q)
);

// File: tb/spi_cmdq_test.sv
`timescale 1ns/1ps
module spi_cmdq_test;
  logic        clk = 1'b0;
  logic        rst_n, tick, wr_en, rd_en, irq, sck, mosi, miso;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic [5:0]  cs_n;

  int checks = 0, errs = 0;
  bit finished = 0;
  int div = 1, tcnt = 0;

  always #2 clk = ~clk;

  spi_cmdq uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .sck(sck),
    .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  assign miso = ~mosi;

  always @(negedge clk) begin
    tick <= (tcnt == 0);
    tcnt <= (tcnt + 1 >= div) ? 0 : tcnt + 1;
  end

  // line monitor
  logic [5:0]  pol_b = 6'h3f;
  bit          cfg_cpol = 0, cfg_cpha = 0;
  logic [15:0] cap;
  int capn, falls1, run1, minrun1, cyc, last_e, minsp, maxsp;
  bit prev_sck = 0, prev_act = 0, prev_cs1 = 1, had_low1 = 0, e_valid = 0, hi2 = 0;
  logic [5:0] lowmask;

  always @(negedge clk) begin
    bit act, lead;
    cyc++;
    act = |(cs_n ^ pol_b);
    if (act && prev_act && sck != prev_sck) begin
      lead = (prev_sck == cfg_cpol);
      if (lead != cfg_cpha) begin
        cap = {cap[14:0], mosi};
        capn++;
      end
      if (e_valid) begin
        if (cyc - last_e < minsp) minsp = cyc - last_e;
        if (cyc - last_e > maxsp) maxsp = cyc - last_e;
      end
      e_valid = 1;
      last_e = cyc;
    end
    if (!act) e_valid = 0;
    lowmask = lowmask | ~cs_n;
    if (cs_n[2]) hi2 = 1;
    if (!cs_n[1] && prev_cs1) begin
      falls1++;
      if (had_low1 && run1 < minrun1) minrun1 = run1;
      run1 = 0;
      had_low1 = 1;
    end else if (cs_n[1]) run1++;
    prev_cs1 = cs_n[1];
    prev_sck = sck;
    prev_act = act;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input bit pop, output logic [31:0] v);
    @(negedge clk); addr = a; rd_en = pop; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_flag();
    int n = 0;
    addr = 4'h1;
    while (n < 5000) begin
      @(negedge clk); #1;
      if (rdata[28]) break;
      n++;
    end
  endtask

  task automatic mon_clear();
    cap = 0; capn = 0; lowmask = 0; falls1 = 0; run1 = 0; minrun1 = 1000;
    had_low1 = 0; minsp = 1000; maxsp = 0; hi2 = 0;
  endtask

  function automatic logic [31:0] cmd(bit keep, int set, bit eoq, bit clr, int line, logic [15:0] d);
    return {keep, 3'(set), eoq, clr, 4'b0, 6'(1 << line), d};
  endfunction

  function automatic logic [31:0] attr(int n, bit cp, bit ch, bit lsb);
    return {1'b0, 4'(n - 1), cp, ch, lsb, 24'b0};
  endfunction

  initial begin
    #(4 * 190000);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [15:0] d, mask, expc;
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    mon_clear();
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // reset state
    chk(cs_n == 6'h3f, "R12 reset cs_n", cs_n, 6'h3f);
    chk(sck == 1'b0, "R5 reset sck", sck, 0);
    chk(irq == 1'b0, "R8 reset irq", irq, 0);
    rd(4'h1, 0, v); chk(v == 0, "R7 reset status", v, 0);
    rd(4'h5, 0, v); chk(v == 0, "R10 reset counter", v, 0);

    // end-of-queue with interrupt disabled, then enabled
    wr(4'h8, attr(8, 0, 0, 0));
    wr(4'h3, cmd(0, 0, 1, 0, 0, 16'h005a));
    repeat (300) @(negedge clk);
    rd(4'h1, 0, v); chk(v[28] == 1'b1, "R7 eoq flag set", v, 32'h1000_0000);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    wr(4'h2, 32'h1000_0000);
    #1 chk(irq == 1'b1, "R8 irq enabled", irq, 1);
    rd(4'h4, 1, v); chk(v == 32'h0000_00a5, "R6 pop word", v, 32'ha5);
    wr(4'h1, 32'h1000_0000);
    #1 chk(irq == 1'b0, "R8 irq after clear", irq, 0);

    // sweep: length x polarity x phase x order, alternating attribute sets
    for (int n = 4; n <= 16; n++) begin
      for (int m = 0; m < 8; m++) begin
        int set = (n + m) % 2;
        int line = (n + m) % 6;
        div = (n % 3) + 1;
        d = 16'((n * 16'h1357) ^ (m * 16'h2c49) ^ 16'ha5c3);
        mask = 16'((32'd1 << n) - 1);
        cfg_cpol = m[2]; cfg_cpha = m[1];
        wr(4'(8 + set), attr(n, m[2], m[1], m[0]));
        mon_clear();
        wr(4'h3, cmd(0, set, 1, (n == 4 && m == 0), line, d));
        wait_flag();
        expc = 0;
        if (m[0]) begin
          for (int b = 0; b < n; b++) expc[n - 1 - b] = d[b];
        end else expc = d & mask;
        chk(capn == n, "R4 bit count", capn, n);
        chk((cap & mask) == expc, "R4 R5 serial order", cap & mask, expc);
        chk(lowmask == 6'(1 << line), "R3 cs line", lowmask, 6'(1 << line));
        chk(sck == m[2], "R5 idle level", sck, m[2]);
        rd(4'h4, 1, v);
        chk(v == {16'b0, ~d & mask}, "R6 R4 received", v, {16'b0, ~d & mask});
        wr(4'h1, 32'h1000_0000);
      end
    end
    div = 1;
    rd(4'h5, 0, v); chk(v == 104, "R10 frame count", v, 104);

    // counter clear, overflow, halt, ordering
    cfg_cpol = 0; cfg_cpha = 0;
    wr(4'h8, attr(8, 0, 0, 0));
    wr(4'h3, cmd(0, 0, 1, 1, 0, 16'h0001));
    wait_flag();
    rd(4'h5, 0, v); chk(v == 1, "R10 clear bit", v, 1);
    rd(4'h4, 1, v);
    for (int k = 1; k <= 5; k++) wr(4'h3, cmd(0, 0, k == 4, 0, 0, 16'(k * 16'h11)));
    rd(4'h1, 0, v); chk(v[0] == 1'b1, "R1 overflow set", v, 32'h1000_0001);
    repeat (200) @(negedge clk);
    rd(4'h5, 0, v); chk(v == 1, "R7 halted", v, 1);
    wr(4'h1, 32'h1000_0001);
    wait_flag();
    rd(4'h5, 0, v); chk(v == 5, "R1 four frames", v, 5);
    rd(4'h1, 0, v); chk(v[0] == 1'b0, "R1 overflow cleared", v[0], 0);
    rd(4'h4, 1, v); chk(v == 32'hee, "R1 order 1", v, 32'hee);
    rd(4'h4, 1, v); chk(v == 32'hdd, "R1 order 2", v, 32'hdd);
    wr(4'h0, 32'h003f_0002);
    rd(4'h4, 1, v); chk(v == 0, "R11 rx flushed", v, 0);
    rd(4'h1, 0, v); chk(v[1] == 1'b1, "R2 underflow", v[1], 1);

    // transmit flush
    wr(4'h3, cmd(0, 0, 0, 0, 0, 16'h0f0f));
    wr(4'h3, cmd(0, 0, 1, 0, 0, 16'hf0f0));
    wr(4'h0, 32'h003f_0001);
    wr(4'h1, 32'h1000_0003);
    repeat (300) @(negedge clk);
    rd(4'h5, 0, v); chk(v == 5, "R11 tx flushed", v, 5);
    rd(4'h1, 0, v); chk(v == 0, "R11 R2 status clear", v, 0);

    // chip-select gap versus keep-asserted
    mon_clear();
    wr(4'h3, cmd(0, 0, 0, 0, 1, 16'h0033));
    wr(4'h3, cmd(0, 0, 1, 0, 1, 16'h0044));
    wait_flag();
    repeat (3) @(negedge clk);
    chk(falls1 == 2, "R9 separate frames", falls1, 2);
    chk(minrun1 >= 2, "R9 gap length", minrun1, 2);
    wr(4'h1, 32'h1000_0000);
    wr(4'h0, 32'h003f_0002);
    mon_clear();
    wr(4'h3, cmd(1, 0, 0, 0, 1, 16'h0055));
    wr(4'h3, cmd(0, 0, 1, 0, 1, 16'h0066));
    wait_flag();
    repeat (3) @(negedge clk);
    chk(falls1 == 1, "R9 kept asserted", falls1, 1);
    wr(4'h1, 32'h1000_0000);
    wr(4'h0, 32'h003f_0002);

    // tick pacing
    div = 4;
    mon_clear();
    wr(4'h3, cmd(0, 0, 1, 0, 3, 16'h00c3));
    wait_flag();
    chk(minsp == 4 && maxsp == 4, "R13 edge spacing", minsp, 4);
    wr(4'h1, 32'h1000_0000);
    wr(4'h0, 32'h003f_0002);
    div = 1;

    // per-line idle level
    wr(4'h0, 32'h003b_0000);
    pol_b = 6'h3b;
    @(negedge clk);
    chk(cs_n == 6'h3b, "R12 idle levels", cs_n, 6'h3b);
    mon_clear();
    wr(4'h3, cmd(0, 0, 1, 0, 2, 16'h0077));
    wait_flag();
    chk(hi2 == 1'b1, "R12 active-high line", hi2, 1);
    chk(lowmask == 6'h04, "R12 other lines idle", lowmask, 6'h04);
    wr(4'h1, 32'h1000_0000);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule